// File: doc/BRIEF.md
# Compact 16-bit branch resolver

This block resolves one 16-bit compact branch or jump per cycle. It takes an instruction word and the address that word was fetched from, and it decodes the form. It drives up to two register indices to an external register file and reads the operand values back in the same cycle. One clock after the valid strobe it presents the results together: a taken flag, the target address, the next fetch address and an optional link write. Encodings it does not recognise raise a reserved-instruction flag. Compact branches have no delay slot, so a branch that is not taken continues at the fetch address plus 2.

Control is a two-state machine. In `S_IDLE` no result is presented. In `S_DONE` the registered result is valid for exactly one cycle. The transition `IDLE->DONE` fires on a valid strobe and `DONE->DONE` fires on a back-to-back strobe. `DONE->IDLE` and `IDLE->IDLE` fire when no strobe arrives. Three-bit register fields are translated to general register numbers through a parameter table. By default the table maps codes 0..7 to registers 16, 17, 18, 19, 4, 5, 6, 7.

Top module: `cbr_resolver`

## Requirements
- R1: `out_valid` is high in exactly the cycle after `in_valid` was sampled high. While `out_valid` is low, `out_taken`, `out_link_we` and `out_rsvd` are low.
- R2: Opcode bits 15:10 = 001010 is an unconditional branch, always taken. Its offset is sign-extended from an 11-bit byte offset: bit 10 comes from instruction bit 0, bits 9:1 come from instruction bits 9:1, and bit 0 is zero. The target is fetch address + 2 + offset.
- R3: Opcode 101010 is branch-and-link. It is always taken, with the same offset and target as R2. It writes fetch address + 2 into register 31 (`out_link_we`=1, `out_link_idx`=31).
- R4: Opcode 100110 branches if the register is zero, and opcode 101110 branches if it is nonzero. The register is named by the 3-bit field in bits 9:7. The offset is an 8-bit signed byte offset: bit 7 comes from instruction bit 0, bits 6:1 come from instruction bits 6:1, and bit 0 is zero. The target is fetch address + 2 + offset, whether or not the branch is taken.
- R5: Under opcode 010010, if bits 3:0 are nonzero the word is a pair-compare branch with field A in bits 6:4 and field B in bits 9:7. It tests equality when A < B numerically, and inequality otherwise. Its offset is bits 3:0 shifted left by one, unsigned.
- R6: Under opcode 010010, if bits 3:0 are zero the word is a register jump. The source register is bits 9:5 and the target is its full value. Bit 4 = 1 also writes fetch address + 2 into register 31. Register index 0 always reads as zero, whatever the register file returns.
- R7: `out_seq_pc` is fetch address + 2. `out_next_pc` equals `out_target` when the branch is taken and `out_seq_pc` when it is not.
- R8: Any other opcode sets `out_rsvd` with `out_taken`=0, `out_link_we`=0, `out_target`=0 and `out_next_pc` = fetch address + 2.
- R9: Each 3-bit register field is translated through the `REG_MAP` parameter before it drives a read port. With the default map, 3-bit codes 0..7 read registers 16..19 and 4..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 16 | Instruction word |
| in_pc | input | XLEN | Fetch address of the word |
| rf_raddr_a | output | 5 | First register read index |
| rf_raddr_b | output | 5 | Second register read index |
| rf_rdata_a | input | XLEN | First read value, same cycle |
| rf_rdata_b | input | XLEN | Second read value, same cycle |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch or jump taken |
| out_target | output | XLEN | Branch target |
| out_next_pc | output | XLEN | Next fetch address |
| out_seq_pc | output | XLEN | Fetch address + 2 |
| out_link_we | output | 1 | Link write enable |
| out_link_idx | output | 5 | Link register index |
| out_link_data | output | XLEN | Link value |
| out_rsvd | output | 1 | Reserved instruction |

## Verification
The hardest case is the pair-compare branch. Its condition flips with the numeric order of the two fields, and the outcome also depends on whether the two mapped registers hold equal values. Equal fields must fall into the inequality test and so are never taken. The stimulus sweeps all 64 field combinations twice: once with the register file filled so that several mapped registers share a value, and once with all values distinct. Register 0 is seeded with a nonzero value so that the forced-zero read in R6 can be seen at the target output.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam logic [5:0] OP_BC    = 6'b001010;
    localparam logic [5:0] OP_BALC  = 6'b101010;
    localparam logic [5:0] OP_BEQZ  = 6'b100110;
    localparam logic [5:0] OP_BNEZ  = 6'b101110;
    localparam logic [5:0] OP_GROUP = 6'b010010;
    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        F_BC, F_BALC, F_BEQZ, F_BNEZ, F_BEQ, F_BNE, F_JR, F_JALR, F_RSVD
    } form_e;

    typedef enum logic { S_IDLE, S_DONE } state_e;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [39:0] REG_MAP = {5'd7, 5'd6, 5'd5, 5'd4, 5'd19, 5'd18, 5'd17, 5'd16}
) (
    input  logic [15:0]     insn,
    output form_e           form,
    output logic [4:0]      idx_a,
    output logic [4:0]      idx_b,
    output logic [XLEN-1:0] offset
);
    logic [5:0] opc;
    logic [2:0] fld_a, fld_b;
    logic [XLEN-1:0] off_long, off_short, off_pair;

    assign opc   = insn[15:10];
    assign fld_a = insn[6:4];
    assign fld_b = insn[9:7];

    assign off_long  = {{(XLEN-11){insn[0]}}, insn[0], insn[9:1], 1'b0};
    assign off_short = {{(XLEN-8){insn[0]}}, insn[0], insn[6:1], 1'b0};
    assign off_pair  = {{(XLEN-5){1'b0}}, insn[3:0], 1'b0};

    always_comb begin
        form   = F_RSVD;
        idx_a  = '0;
        idx_b  = '0;
        offset = '0;
        unique case (opc)
            OP_BC:   begin form = F_BC;   offset = off_long; end
            OP_BALC: begin form = F_BALC; offset = off_long; end
            OP_BEQZ: begin
                form = F_BEQZ; offset = off_short; idx_a = REG_MAP[5*fld_b +: 5];
            end
            OP_BNEZ: begin
                form = F_BNEZ; offset = off_short; idx_a = REG_MAP[5*fld_b +: 5];
            end
            OP_GROUP: begin
                if (insn[3:0] == 4'd0) begin
                    form  = insn[4] ? F_JALR : F_JR;
                    idx_a = insn[9:5];
                end else begin
                    form   = (fld_a < fld_b) ? F_BEQ : F_BNE;
                    idx_a  = REG_MAP[5*fld_a +: 5];
                    idx_b  = REG_MAP[5*fld_b +: 5];
                    offset = off_pair;
                end
            end
            default: form = F_RSVD;
        endcase
    end
endmodule

// File: rtl/cbr_eval.sv
module cbr_eval
    import cbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  form_e           form,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            taken,
    output logic            link_we,
    output logic            rsvd,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] seq_pc
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

    logic [XLEN-1:0] rel_tgt;

    assign seq_pc  = pc + INSN_BYTES;
    assign rel_tgt = seq_pc + offset;

    always_comb begin
        taken   = 1'b0;
        link_we = 1'b0;
        rsvd    = 1'b0;
        target  = rel_tgt;
        unique case (form)
            F_BC:   taken = 1'b1;
            F_BALC: begin taken = 1'b1; link_we = 1'b1; end
            F_BEQZ: taken = (opa == '0);
            F_BNEZ: taken = (opa != '0);
            F_BEQ:  taken = (opa == opb);
            F_BNE:  taken = (opa != opb);
            F_JR:   begin taken = 1'b1; target = opa; end
            F_JALR: begin taken = 1'b1; target = opa; link_we = 1'b1; end
            default: begin rsvd = 1'b1; target = '0; end
        endcase
        next_pc = taken ? target : seq_pc;
    end
endmodule

// File: rtl/cbr_resolver.sv
module cbr_resolver
    import cbr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [39:0] REG_MAP = {5'd7, 5'd6, 5'd5, 5'd4, 5'd19, 5'd18, 5'd17, 5'd16}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [15:0]     in_insn,
    input  logic [XLEN-1:0] in_pc,
    output logic [4:0]      rf_raddr_a,
    output logic [4:0]      rf_raddr_b,
    input  logic [XLEN-1:0] rf_rdata_a,
    input  logic [XLEN-1:0] rf_rdata_b,
    output logic            out_valid,
    output logic            out_taken,
    output logic [XLEN-1:0] out_target,
    output logic [XLEN-1:0] out_next_pc,
    output logic [XLEN-1:0] out_seq_pc,
    output logic            out_link_we,
    output logic [4:0]      out_link_idx,
    output logic [XLEN-1:0] out_link_data,
    output logic            out_rsvd
);
    state_e state_q, state_d;
    form_e  form;
    logic [XLEN-1:0] offset, opa, opb, c_target, c_next, c_seq;
    logic c_taken, c_link, c_rsvd;

    cbr_decode #(.XLEN(XLEN), .REG_MAP(REG_MAP)) u_dec (
        .insn(in_insn), .form(form), .idx_a(rf_raddr_a),
        .idx_b(rf_raddr_b), .offset(offset)
    );

    assign opa = (rf_raddr_a == 5'd0) ? '0 : rf_rdata_a;
    assign opb = (rf_raddr_b == 5'd0) ? '0 : rf_rdata_b;

    cbr_eval #(.XLEN(XLEN)) u_eval (
        .form(form), .pc(in_pc), .offset(offset), .opa(opa), .opb(opb),
        .taken(c_taken), .link_we(c_link), .rsvd(c_rsvd),
        .target(c_target), .next_pc(c_next), .seq_pc(c_seq)
    );

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_DONE : S_IDLE;
            S_DONE:  state_d = in_valid ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_taken     <= 1'b0;
            out_link_we   <= 1'b0;
            out_rsvd      <= 1'b0;
            out_target    <= '0;
            out_next_pc   <= '0;
            out_seq_pc    <= '0;
            out_link_data <= '0;
        end else if (in_valid) begin
            out_taken     <= c_taken;
            out_link_we   <= c_link;
            out_rsvd      <= c_rsvd;
            out_target    <= c_target;
            out_next_pc   <= c_next;
            out_seq_pc    <= c_seq;
            out_link_data <= c_seq;
        end else begin
            out_taken     <= 1'b0;
            out_link_we   <= 1'b0;
            out_rsvd      <= 1'b0;
        end
    end

    assign out_valid    = (state_q == S_DONE);
    assign out_link_idx = LINK_REG;
endmodule

// File: rtl/cbr_resolver_chk.sv
module cbr_resolver_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_pc,
    input logic            out_valid,
    input logic            out_taken,
    input logic [XLEN-1:0] out_target,
    input logic [XLEN-1:0] out_next_pc,
    input logic [XLEN-1:0] out_seq_pc,
    input logic            out_link_we,
    input logic [4:0]      out_link_idx,
    input logic [XLEN-1:0] out_link_data,
    input logic            out_rsvd
);
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_taken && !out_link_we && !out_rsvd)); // R1
    AST_LINK_TO_RA: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_link_idx == 5'd31 && out_link_data == out_seq_pc)); // R3
    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_seq_pc == $past(in_pc) + XLEN'(2))); // R7
    AST_NEXT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_next_pc == (out_taken ? out_target : out_seq_pc))); // R7
    AST_RSVD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        out_rsvd |-> (!out_taken && !out_link_we)); // R8
endmodule

bind cbr_resolver cbr_resolver_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .out_next_pc(out_next_pc), .out_seq_pc(out_seq_pc),
    .out_link_we(out_link_we), .out_link_idx(out_link_idx),
    .out_link_data(out_link_data), .out_rsvd(out_rsvd)
);

// File: tb/tb_cbr_resolver.sv
module tb_cbr_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_insn = '0;
    logic [31:0] in_pc = '0;
    logic [4:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        out_valid, out_taken, out_link_we, out_rsvd;
    logic [31:0] out_target, out_next_pc, out_seq_pc, out_link_data;
    logic [4:0]  out_link_idx;

    logic [31:0] rf [32];
    int checks = 0;
    int errors = 0;
    int tbl [8] = '{16, 17, 18, 19, 4, 5, 6, 7};

    always #4 clk = ~clk;

    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];

    cbr_resolver dut (.*);

    typedef struct {
        bit          pend;
        bit          taken, link, rsvd;
        logic [31:0] target, next_pc, seq;
        string       req;
    } exp_t;
    exp_t pending;

    function automatic logic [31:0] rv(int i);
        return (i == 0) ? 32'd0 : rf[i];
    endfunction

    function automatic exp_t model(logic [15:0] w, logic [31:0] pc);
        exp_t e;
        int op = int'(w[15:10]);
        longint off;
        e.pend = 1; e.taken = 0; e.link = 0; e.rsvd = 0;
        e.seq = pc + 32'd2; e.target = 0; e.req = "R8";
        if (op == 10 || op == 42) begin
            off = longint'(w[9:1]) * 2 - (w[0] ? 1024 : 0);
            e.target = e.seq + 32'(off); e.taken = 1;
            e.link = (op == 42); e.req = (op == 42) ? "R3" : "R2";
        end else if (op == 38 || op == 46) begin
            off = longint'(w[6:1]) * 2 - (w[0] ? 128 : 0);
            e.target = e.seq + 32'(off);
            e.taken = (op == 38) ? (rv(tbl[w[9:7]]) == 0) : (rv(tbl[w[9:7]]) != 0);
            e.req = "R4";
        end else if (op == 18) begin
            if (w[3:0] == 0) begin
                e.target = rv(int'(w[9:5])); e.taken = 1; e.link = w[4]; e.req = "R6";
            end else begin
                e.target = e.seq + 32'(int'(w[3:0]) * 2);
                if (int'(w[6:4]) < int'(w[9:7]))
                    e.taken = (rv(tbl[w[6:4]]) == rv(tbl[w[9:7]]));
                else
                    e.taken = (rv(tbl[w[6:4]]) != rv(tbl[w[9:7]]));
                e.req = "R5";
            end
        end else begin
            e.rsvd = 1;
        end
        e.next_pc = e.taken ? e.target : e.seq;
        return e;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!pending.pend) begin
            chk("R1", "idle valid", 32'(out_valid), 0);
            chk("R1", "idle taken", 32'(out_taken), 0);
        end else begin
            chk("R1", "valid", 32'(out_valid), 1);
            chk(pending.req, "taken", 32'(out_taken), 32'(pending.taken));
            chk(pending.req, "target", out_target, pending.target);
            chk("R7", "next_pc", out_next_pc, pending.next_pc);
            chk("R7", "seq_pc", out_seq_pc, pending.seq);
            chk("R8", "rsvd", 32'(out_rsvd), 32'(pending.rsvd));
            chk(pending.link ? "R3" : pending.req, "link_we", 32'(out_link_we), 32'(pending.link));
            if (pending.link) begin
                chk("R3", "link_idx", 32'(out_link_idx), 31);
                chk("R3", "link_data", out_link_data, pending.seq);
            end
        end
    endtask

    task automatic step(bit v, logic [15:0] w, logic [31:0] pc);
        @(negedge clk);
        compare();
        in_valid = v; in_insn = w; in_pc = pc;
        #1;
        if (v) pending = model(w, pc); else pending.pend = 0;
    endtask

    task automatic fill(bit dup);
        for (int i = 0; i < 32; i++) rf[i] = 32'h1000 + 32'(i) * 32'h11;
        rf[0] = 32'hDEAD_BEEF;
        rf[17] = 0;
        if (dup) begin rf[16] = 32'h55; rf[19] = 32'h55; rf[5] = 32'h55; end
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pending.pend = 0;
        fill(0);
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", 32'(out_valid), 0);
        chk("R1", "reset link", 32'(out_link_we), 0);
        rst_n = 1'b1;
        // R2: forward and backward unconditional
        step(1, {6'b001010, 9'h1FF, 1'b0}, 32'h0000_4000);
        step(1, {6'b001010, 9'h000, 1'b1}, 32'h0000_4000);
        // R3: branch-and-link, negative offset
        step(1, {6'b101010, 9'h0AA, 1'b1}, 32'h0001_0000);
        step(0, 16'h0, 32'h0);
        // R4 + R9: zero compare on map code 1 (reg 17 = 0) and code 2
        step(1, {6'b100110, 3'd1, 6'h3F, 1'b1}, 32'h0000_0100);
        step(1, {6'b100110, 3'd2, 6'h05, 1'b0}, 32'h0000_0100);
        step(1, {6'b101110, 3'd1, 6'h05, 1'b0}, 32'h0000_0100);
        step(1, {6'b101110, 3'd6, 6'h21, 1'b1}, 32'h0000_0100);
        // R6: register jumps, including register 0 forced to zero
        step(1, {6'b010010, 5'd9, 1'b0, 4'd0}, 32'h0000_0200);
        step(1, {6'b010010, 5'd0, 1'b1, 4'd0}, 32'h0000_0200);
        step(1, {6'b010010, 5'd31, 1'b1, 4'd0}, 32'h0000_0200);
        // R8: reserved opcodes
        step(1, 16'hFFFF, 32'h0000_0300);
        step(1, 16'h0000, 32'h0000_0300);
        // R5 + R9: full pair-field sweep, distinct then shared values
        for (int pass = 0; pass < 2; pass++) begin
            step(0, 16'h0, 32'h0);
            fill(pass[0]);
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    step(1, {6'b010010, 3'(b), 3'(a), 4'(1 + a)}, 32'h0000_8000 + 32'(a * 64));
        end
        // R1: gaps between strobes, mixed random words
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w = 16'($urandom);
            int sel = i % 6;
            if (sel == 0) w[15:10] = 6'b001010;
            if (sel == 1) w[15:10] = 6'b101010;
            if (sel == 2) w[15:10] = 6'b100110;
            if (sel == 3) w[15:10] = 6'b101110;
            if (sel == 4) w[15:10] = 6'b010010;
            step((i % 7) != 3, w, $urandom);
        end
        step(0, 16'h0, 32'h0);
        step(0, 16'h0, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule